// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block collects up to 32 external interrupt lines, latches each one into a status bit and drives a single interrupt request toward a processor. Software reaches it over a small word-addressed register port. The port has a write strobe, a read strobe, a 3-bit word address and 32-bit data. Each source is fixed at elaboration time as either edge-triggered or level-sensitive. Every input passes through a synchronizer before it is captured.

Software controls which sources may raise the request. It can load the enable word as a whole, or set or clear single enable bits without a read-modify-write. Latched sources are cleared by writing ones to the acknowledge word. A vector word reports the lowest-numbered source that is both latched and enabled, so source 0 has the highest priority. The request line also needs both bits of a two-bit master control word before it can assert.

Top module: `irq_hub`

## Requirements
- R1: After reset the status, enable and master words read zero, the vector word reads 0xFFFFFFFF and `irq_o` is low.
- R2: A write to word 4 ORs the data into the enable bits and leaves all other enable bits unchanged. A write to word 2 loads the enable bits directly.
- R3: A write to word 5 clears the enable bits set in the data and leaves all other enable bits unchanged.
- R4: Words 3, 4 and 5 read as zero. Writes to words 0 (status), 1 (pending) and 6 (vector) change nothing.
- R5: A source whose `EDGE_MASK` bit is 1 sets its status bit within SYNC_STAGES+1 clocks of a 0-to-1 input change, whatever its enable bit is. The status bit stays set after the input falls. An input held high does not set the bit again after it is acknowledged.
- R6: A source whose `EDGE_MASK` bit is 0 sets its status bit on every clock in which its synchronized input is high. An acknowledge written while the input is still high leaves the bit set. Once the input is low, an acknowledge clears it.
- R7: Writing a mask to word 3 clears the matching status bits, and all-ones clears every latched bit. A new capture in the same clock takes precedence over the acknowledge.
- R8: Word 1 reads the bitwise AND of status and enable.
- R9: Word 6 reads the index of the lowest-numbered pending source, zero-extended. It reads 0xFFFFFFFF when nothing is pending.
- R10: `irq_o` is high only while some source is pending and both master bits (bit 0 and bit 1 of word 7) are 1. Word 7 reads back those two bits with all upper bits zero.
- R11: Read data appears on `bus_rdata` one clock after `bus_re` is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Raw interrupt inputs |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The capture logic is driven with several input shapes. A short pulse on an edge source must stay latched after the input falls. An edge input held high through an acknowledge must not be captured again, which is what separates edge behaviour from level behaviour. A level input held high through an acknowledge must set its bit again, and the same input after it falls must clear for good. Two sources latched at once, under different enable masks, show that the vector follows the enabled source with the lowest index rather than simply the lowest latched bit. Stepping the master word through 0, 1 and 3 shows that both bits are needed before the request asserts.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        WORD_STATUS = 3'd0,
        WORD_PEND   = 3'd1,
        WORD_EN     = 3'd2,
        WORD_ACK    = 3'd3,
        WORD_EN_SET = 3'd4,
        WORD_EN_CLR = 3'd5,
        WORD_VEC    = 3'd6,
        WORD_MASTER = 3'd7
    } word_t;

    localparam logic [BUS_W-1:0] NO_VECTOR = '1;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int unsigned N_SRC       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw_i,
    output logic [N_SRC-1:0] sync_o
);

    logic [N_SRC-1:0] stg_d [SYNC_STAGES];
    logic [N_SRC-1:0] stg_q [SYNC_STAGES];

    always_comb begin
        stg_d[0] = raw_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[SYNC_STAGES-1];

endmodule

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
    parameter int unsigned N_SRC     = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_i,
    output logic [N_SRC-1:0] set_o
);

    logic [N_SRC-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            if (EDGE_MASK[g]) begin : g_edge
                assign set_o[g] = sync_i[g] & ~prev_q[g];
            end else begin : g_level
                assign set_o[g] = sync_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
    parameter int unsigned N_SRC = 32,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned N_SRC       = 32,
    parameter logic [31:0] EDGE_MASK   = 32'h0000_FFFF,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_i,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 irq_o
);

    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] enable;
        logic [1:0]       master;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [N_SRC-1:0] sync_w;
    logic [N_SRC-1:0] set_w;
    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] en_w;
    logic [N_SRC-1:0] status_w;
    logic [1:0]       master_w;
    logic             vec_hit;
    logic [IDX_W-1:0] vec_idx;

    irq_hub_sync #(
        .N_SRC      (N_SRC),
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (src_i),
        .sync_o(sync_w)
    );

    irq_hub_capture #(
        .N_SRC    (N_SRC),
        .EDGE_MASK(EDGE_MASK)
    ) i_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .sync_i(sync_w),
        .set_o (set_w)
    );

    irq_hub_prio #(
        .N_SRC(N_SRC)
    ) i_prio (
        .req_i(pend_w),
        .hit_o(vec_hit),
        .idx_o(vec_idx)
    );

    assign en_w     = st_q.enable;
    assign status_w = st_q.status;
    assign master_w = st_q.master;
    assign pend_w   = st_q.status & st_q.enable;
    assign irq_o    = (|pend_w) & st_q.master[0] & st_q.master[1];

    always_comb begin
        logic [N_SRC-1:0] ack_mask;
        logic [N_SRC-1:0] wmask;
        logic [BUS_W-1:0] rd;

        st_d  = st_q;
        wmask = bus_wdata[N_SRC-1:0];

        ack_mask = '0;
        if (bus_we && word_t'(bus_addr) == WORD_ACK) begin
            ack_mask = wmask;
        end
        // capture wins over acknowledge in the same cycle
        st_d.status = (st_q.status & ~ack_mask) | set_w;

        if (bus_we) begin
            unique case (word_t'(bus_addr))
                WORD_EN:     st_d.enable = wmask;
                WORD_EN_SET: st_d.enable = st_q.enable | wmask;
                WORD_EN_CLR: st_d.enable = st_q.enable & ~wmask;
                WORD_MASTER: st_d.master = bus_wdata[1:0];
                default:     ;
            endcase
        end

        rd = '0;
        unique case (word_t'(bus_addr))
            WORD_STATUS: rd[N_SRC-1:0] = st_q.status;
            WORD_PEND:   rd[N_SRC-1:0] = pend_w;
            WORD_EN:     rd[N_SRC-1:0] = st_q.enable;
            WORD_VEC:    begin
                if (vec_hit) rd[IDX_W-1:0] = vec_idx;
                else         rd = NO_VECTOR;
            end
            WORD_MASTER: rd[1:0] = st_q.master;
            default:     rd = '0;
        endcase
        if (bus_re) begin
            st_d.rdata = rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int unsigned N_SRC = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             bus_re,
    input logic [2:0]       bus_addr,
    input logic [N_SRC-1:0] wmask,
    input logic [31:0]      bus_rdata,
    input logic             irq_o,
    input logic [N_SRC-1:0] en_w,
    input logic [N_SRC-1:0] status_w,
    input logic [N_SRC-1:0] set_w,
    input logic [N_SRC-1:0] pend_w,
    input logic [1:0]       master_w
);

    logic             seen_q;
    logic [N_SRC-1:0] ack_now;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign ack_now = (bus_we && bus_addr == 3'd3) ? wmask : '0;

    a_r2_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd4) |=> en_w == ($past(en_w) | $past(wmask)));

    a_r3_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd5) |=> en_w == ($past(en_w) & ~$past(wmask)));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd3) |=> (status_w & $past(wmask) & ~$past(set_w)) == '0);

    a_r5_status_latched: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (($past(status_w) & ~$past(ack_now)) & ~status_w) == '0);

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (master_w == 2'b11 && pend_w != '0));

    a_r9_empty_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 3'd6 && pend_w == '0) |=> bus_rdata == 32'hFFFF_FFFF);

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(bus_re)) |-> $stable(bus_rdata));

endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC)) i_irq_hub_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_addr (bus_addr),
    .wmask    (bus_wdata[N_SRC-1:0]),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .en_w     (en_w),
    .status_w (status_w),
    .set_w    (set_w),
    .pend_w   (pend_w),
    .master_w (master_w)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;
    localparam int E_SRC = 3;
    localparam int L_SRC = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [2:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub #(
        .N_SRC      (NSRC),
        .EDGE_MASK  (32'h0000_FFFF),
        .SYNC_STAGES(2)
    ) i_irq_hub (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_word(input logic [2:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        check(irq_o === 1'b0, "R1 irq", {31'b0, irq_o}, 32'h0);
        expect_word(3'd0, 32'h0, "R1 status");
        expect_word(3'd2, 32'h0, "R1 enable");
        expect_word(3'd7, 32'h0, "R1 master");
        expect_word(3'd6, 32'hFFFF_FFFF, "R1 vector");
    endtask

    task automatic t_enable_ops();
        wr(3'd2, 32'h0000_00F0);
        wr(3'd4, 32'h0000_0003);
        expect_word(3'd2, 32'h0000_00F3, "R2 set-enable");
        wr(3'd5, 32'h0000_0030);
        expect_word(3'd2, 32'h0000_00C3, "R3 clear-enable");
        expect_word(3'd3, 32'h0, "R4 ack reads zero");
        expect_word(3'd4, 32'h0, "R4 set word reads zero");
        expect_word(3'd5, 32'h0, "R4 clear word reads zero");
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        expect_word(3'd0, 32'h0, "R4 status write ignored");
        expect_word(3'd2, 32'h0000_00C3, "R4 enable untouched");
        wr(3'd2, 32'h0);
    endtask

    task automatic t_edge();
        @(negedge clk) src_i[E_SRC] = 1'b1;
        settle();
        expect_word(3'd0, 32'h1 << E_SRC, "R5 edge captured while disabled");
        @(negedge clk) src_i[E_SRC] = 1'b0;
        settle();
        expect_word(3'd0, 32'h1 << E_SRC, "R5 edge latched after fall");
        wr(3'd3, 32'h1 << E_SRC);
        expect_word(3'd0, 32'h0, "R7 ack clears edge bit");
        @(negedge clk) src_i[E_SRC] = 1'b1;
        settle();
        wr(3'd3, 32'h1 << E_SRC);
        settle();
        expect_word(3'd0, 32'h0, "R5 held edge not recaptured");
        @(negedge clk) src_i[E_SRC] = 1'b0;
        settle();
    endtask

    task automatic t_level();
        @(negedge clk) src_i[L_SRC] = 1'b1;
        settle();
        expect_word(3'd0, 32'h1 << L_SRC, "R6 level captured");
        wr(3'd3, 32'hFFFF_FFFF);
        expect_word(3'd0, 32'h1 << L_SRC, "R6 R7 level resets after ack");
        @(negedge clk) src_i[L_SRC] = 1'b0;
        settle();
        wr(3'd3, 32'h1 << L_SRC);
        expect_word(3'd0, 32'h0, "R6 level cleared once low");
    endtask

    task automatic t_pend_vec();
        @(negedge clk) begin src_i[E_SRC] = 1'b1; src_i[L_SRC] = 1'b1; end
        settle();
        @(negedge clk) begin src_i[E_SRC] = 1'b0; src_i[L_SRC] = 1'b0; end
        settle();
        expect_word(3'd0, (32'h1 << E_SRC) | (32'h1 << L_SRC), "R5 R6 both latched");
        wr(3'd2, 32'h1 << L_SRC);
        expect_word(3'd1, 32'h1 << L_SRC, "R8 pending masked");
        expect_word(3'd6, L_SRC, "R9 vector single");
        check(irq_o === 1'b0, "R10 irq off with master 0", {31'b0, irq_o}, 32'h0);
        wr(3'd7, 32'h1);
        check(irq_o === 1'b0, "R10 irq off with master 1", {31'b0, irq_o}, 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        check(irq_o === 1'b1, "R10 irq on with master 3", {31'b0, irq_o}, 32'h1);
        expect_word(3'd7, 32'h3, "R10 master readback");
        wr(3'd4, 32'h1 << E_SRC);
        expect_word(3'd6, E_SRC, "R9 lowest index wins");
        expect_word(3'd1, (32'h1 << E_SRC) | (32'h1 << L_SRC), "R8 pending both");
        wr(3'd3, 32'hFFFF_FFFF);
        expect_word(3'd0, 32'h0, "R7 ack all ones");
        expect_word(3'd6, 32'hFFFF_FFFF, "R9 vector empty");
        check(irq_o === 1'b0, "R10 irq off when nothing pending", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_rdata_hold();
        logic [31:0] v;
        rd(3'd2, v);
        check(v === ((32'h1 << E_SRC) | (32'h1 << L_SRC)), "R11 read value", v,
              (32'h1 << E_SRC) | (32'h1 << L_SRC));
        wr(3'd2, 32'h0);
        repeat (3) @(negedge clk);
        check(bus_rdata === v, "R11 rdata held without read", bus_rdata, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_ops();
        t_edge();
        t_level();
        t_pend_vec();
        t_rdata_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule